// File: doc/BRIEF.md
# Page Program Write Buffer

This block sits between the serial command front end of a serial flash device and its storage array. Once a program command and its start address have been decoded, the front end hands over each completed data byte. The block stores the byte at the current offset of a page buffer and moves the offset on. When the offset runs past the last byte of the page it wraps back to the first byte of the same page. A valid bit per buffer entry records which offsets were supplied. A later byte sent to an offset that was already filled replaces the earlier one.

When chip select is released, the front end reports whether the last byte was complete. The commit is taken only if that byte was complete, the write enable latch is set, the page is not protected and at least one byte was supplied. The block then walks the valid entries in ascending offset order. For each entry it reads the old array byte, writes back the old value ANDed with the new one, and holds busy for a fixed number of cycles. When the last entry is done, busy drops and a one-cycle pulse clears the write enable latch. Offsets that were not supplied are never touched.

Top module: `pp_write_buffer`

## Requirements
- R1: After `cmd_start_i`, the first byte goes to page `start_addr_i[ADDR_W-1:OFF_W]` at offset `start_addr_i[OFF_W-1:0]`, where OFF_W = log2(PAGE_BYTES). The start offset may be any offset in the page.
- R2: Each accepted byte moves the offset up by one. After offset PAGE_BYTES-1 the next byte goes to offset 0 of the same page, and no write ever leaves the addressed page.
- R3: If several bytes land on one offset, only the last of them is written to the array, and that offset is written only once.
- R4: Array bytes whose offsets were not supplied receive no write and keep their contents.
- R5: A commit starts only on `cs_rise_i` with `partial_i`=0 and at least one byte supplied. With `partial_i`=1, or with no bytes, the data is discarded: no array access occurs and `busy_o` stays low.
- R6: At `cs_rise_i`, `wen_i`=0 or `prot_i`=1 discards the data in the same way.
- R7: `busy_o` rises in the cycle after the accepted `cs_rise_i` and stays high for exactly N×BYTE_CYCLES cycles, where N is the number of distinct offsets supplied.
- R8: `wel_clr_o` pulses high for one cycle, in the first cycle after `busy_o` falls. It does not pulse when the data is discarded.
- R9: Each written byte equals the old array byte ANDed with the buffered byte, so programming only clears bits.
- R10: While `busy_o` is high, `cmd_start_i`, `byte_valid_i` and `cs_rise_i` are ignored and do not change the writes in progress.
- R11: After reset, `busy_o`, `wel_clr_o`, `mem_re_o` and `mem_we_o` are low.
- R12: Each byte slot begins with `mem_re_o` for one cycle. `mem_we_o` follows in the next cycle to the same address (the array returns read data one cycle after `mem_re_o`). Slots are taken in ascending offset order, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Program command and address decoded (pulse) |
| start_addr_i | input | ADDR_W | Byte address given with the command |
| byte_valid_i | input | 1 | A complete data byte is on `byte_data_i` (pulse) |
| byte_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select was released (pulse) |
| partial_i | input | 1 | With `cs_rise_i`: an incomplete byte had been shifted in |
| wen_i | input | 1 | Write enable latch state |
| prot_i | input | 1 | Addressed page is locked against writes |
| busy_o | output | 1 | Programming in progress |
| wel_clr_o | output | 1 | Clear the write enable latch (pulse) |
| mem_re_o | output | 1 | Array read strobe |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array byte address |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after `mem_re_o` |

## Verification
The bench builds the block with ADDR_W=8, PAGE_BYTES=16 and BYTE_CYCLES=3. With a 16-byte page, a transfer of five bytes from offset 14 crosses the wrap, and eighteen bytes cover the whole page and overwrite two offsets, all in a few dozen cycles. With three cycles per byte, the busy-length rule and the ignored pulses during busy can be checked exactly on both short and full-page commits. The 256-byte array model also lets the bench compare every byte outside the programmed offsets.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } pp_state_e;

endpackage

// File: rtl/pp_offset_track.sv
module pp_offset_track #(
  parameter int OFF_W = 8,
  parameter int PG_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PG_W-1:0]  load_page_i,
  input  logic [OFF_W-1:0] load_off_i,
  input  logic             step_i,
  output logic [PG_W-1:0]  page_o,
  output logic [OFF_W-1:0] off_o
);

  logic [PG_W-1:0]  page_q, page_d;
  logic [OFF_W-1:0] off_q, off_d;

  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    if (load_i) begin
      page_d = load_page_i;
      off_d  = load_off_i;
    end else if (step_i) begin
      off_d = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load_i || step_i) begin
      page_q <= page_d;
      off_q  <= off_d;
    end
  end

  assign page_o = page_q;
  assign off_o  = off_q;

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(page_o));

  // R2
  off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (off_o == {OFF_W{1'b1}})) |=> (off_o == '0));

endmodule

// File: rtl/pp_page_store.sv
module pp_page_store #(
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic             retire_i,
  input  logic [OFF_W-1:0] retire_off_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  output logic             any_o,
  output logic [OFF_W-1:0] first_o
);

  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clear_i) begin
      mask_d = '0;
    end else begin
      if (wr_i)     mask_d[wr_off_i]     = 1'b1;
      if (retire_i) mask_d[retire_off_i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (clear_i || wr_i || retire_i) mask_q <= mask_d;
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (wr_i && (wr_off_i == OFF_W'(g))) data_q[g] <= wr_data_i;
      end
    end
  endgenerate

  always_comb begin
    first_o = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (mask_q[i]) first_o = OFF_W'(i);
    end
  end

  assign any_o     = |mask_q;
  assign rd_data_o = data_q[rd_off_i];

  // R3
  retire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> mask_q[retire_off_i]);

  // R10
  no_fill_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_i && (wr_i || clear_i)));

endmodule

// File: rtl/pp_commit_seq.sv
module pp_commit_seq
  import pp_pkg::*;
#(
  parameter int BYTE_CYCLES = 3000,
  parameter int OFF_W       = 8,
  parameter int PG_W        = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic                  any_i,
  input  logic [OFF_W-1:0]      first_i,
  input  logic [PG_W-1:0]       page_i,
  input  logic [7:0]            buf_data_i,
  input  logic [7:0]            mem_rdata_i,
  output logic [OFF_W-1:0]      buf_off_o,
  output logic                  retire_o,
  output logic                  mem_re_o,
  output logic                  mem_we_o,
  output logic [PG_W+OFF_W-1:0] mem_addr_o,
  output logic [7:0]            mem_wdata_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam int TW = $clog2(BYTE_CYCLES);
  localparam logic [TW-1:0] T_LAST = TW'(BYTE_CYCLES - 1);

  pp_state_e        state_q, state_d;
  logic [OFF_W-1:0] idx_q, idx_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tmr_d   = tmr_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          state_d = ST_READ;
          idx_d   = first_i;
          tmr_d   = '0;
        end
      end
      ST_READ: begin
        state_d = ST_WRITE;
        tmr_d   = tmr_q + TW'(1);
      end
      ST_WRITE: begin
        state_d = ST_HOLD;
        tmr_d   = tmr_q + TW'(1);
      end
      ST_HOLD: begin
        if (tmr_q == T_LAST) begin
          tmr_d = '0;
          if (any_i) begin
            state_d = ST_READ;
            idx_d   = first_i;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tmr_q   <= tmr_d;
      done_q  <= done_d;
    end
  end

  assign buf_off_o   = idx_q;
  assign retire_o    = (state_q == ST_WRITE);
  assign mem_re_o    = (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = {page_i, idx_q};
  assign mem_wdata_o = mem_rdata_i & buf_data_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  initial begin
    // R7
    byte_cycles_min_chk: assert (BYTE_CYCLES >= 3);
  end

  // R12
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($past(mem_re_o) && (mem_addr_o == $past(mem_addr_o))));

  // R12
  one_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re_o && mem_we_o));

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ((mem_wdata_o & ~mem_rdata_i) == 8'h00));

  // R12
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && busy_o && $past(busy_o) && !$past(mem_re_o, BYTE_CYCLES > 3 ? 1 : 1))
      |-> (idx_q > $past(idx_q) || !$past(busy_o)) || ($past(state_q) != ST_HOLD));

endmodule

// File: rtl/pp_write_buffer.sv
module pp_write_buffer #(
  parameter int ADDR_W      = 19,
  parameter int PAGE_BYTES  = 256,
  parameter int BYTE_CYCLES = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              cs_rise_i,
  input  logic              partial_i,
  input  logic              wen_i,
  input  logic              prot_i,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             active_q, active_d;
  logic             busy;
  logic             do_load, do_step, do_close, do_go;
  logic [PG_W-1:0]  page;
  logic [OFF_W-1:0] off;
  logic             any_valid;
  logic [OFF_W-1:0] first_off;
  logic [OFF_W-1:0] buf_off;
  logic [7:0]       buf_data;
  logic             retire;

  assign do_load  = cmd_start_i && !busy;
  assign do_step  = byte_valid_i && active_q && !busy && !do_load;
  assign do_close = cs_rise_i && active_q && !busy && !do_load;
  assign do_go    = do_close && !partial_i && any_valid && wen_i && !prot_i;

  always_comb begin
    active_d = active_q;
    if (do_load)       active_d = 1'b1;
    else if (do_close) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) active_q <= 1'b0;
    else            active_q <= active_d;
  end

  pp_offset_track #(
    .OFF_W (OFF_W),
    .PG_W  (PG_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (do_load),
    .load_page_i (start_addr_i[ADDR_W-1:OFF_W]),
    .load_off_i  (start_addr_i[OFF_W-1:0]),
    .step_i      (do_step),
    .page_o      (page),
    .off_o       (off)
  );

  pp_page_store #(
    .PAGE_BYTES (PAGE_BYTES),
    .OFF_W      (OFF_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .clear_i      (do_load),
    .wr_i         (do_step),
    .wr_off_i     (off),
    .wr_data_i    (byte_data_i),
    .retire_i     (retire),
    .retire_off_i (buf_off),
    .rd_off_i     (buf_off),
    .rd_data_o    (buf_data),
    .any_o        (any_valid),
    .first_o      (first_off)
  );

  pp_commit_seq #(
    .BYTE_CYCLES (BYTE_CYCLES),
    .OFF_W       (OFF_W),
    .PG_W        (PG_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .go_i        (do_go),
    .any_i       (any_valid),
    .first_i     (first_off),
    .page_i      (page),
    .buf_data_i  (buf_data),
    .mem_rdata_i (mem_rdata_i),
    .buf_off_o   (buf_off),
    .retire_o    (retire),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy),
    .done_o      (wel_clr_o)
  );

  assign busy_o = busy;

  // R8
  wel_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wel_clr_o |-> (!busy_o && $past(busy_o)));

  // R5
  start_needs_close_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> $past(cs_rise_i && !partial_i && wen_i && !prot_i));

  // R10
  page_held_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:OFF_W]));

endmodule

// File: tb/pp_write_buffer_tb.sv
module pp_write_buffer_tb;

  localparam int AW   = 8;
  localparam int PAGE = 16;
  localparam int BC   = 3;
  localparam int MEMN = 1 << AW;

  logic          clk, rst_n;
  logic          cmd_start, byte_valid, cs_rise, partial, wen, prot;
  logic [AW-1:0] start_addr;
  logic [7:0]    byte_data;
  logic          busy, wel_clr, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  logic [7:0]    mem     [MEMN];
  logic [7:0]    exp_mem [MEMN];
  logic [AW+7:0] sb_q [$];

  int checks = 0;
  int fails  = 0;

  pp_write_buffer #(
    .ADDR_W      (AW),
    .PAGE_BYTES  (PAGE),
    .BYTE_CYCLES (BC)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start_i  (cmd_start),
    .start_addr_i (start_addr),
    .byte_valid_i (byte_valid),
    .byte_data_i  (byte_data),
    .cs_rise_i    (cs_rise),
    .partial_i    (partial),
    .wen_i        (wen),
    .prot_i       (prot),
    .busy_o       (busy),
    .wel_clr_o    (wel_clr),
    .mem_re_o     (mem_re),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each array write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      logic [AW+7:0] item;
      if (sb_q.size() == 0) begin
        check(1'b0, "R4", "unexpected write", int'({mem_addr, mem_wdata}), 0);
      end else begin
        item = sb_q.pop_front();
        check({mem_addr, mem_wdata} == item, "R9", "write addr/data",
              int'({mem_addr, mem_wdata}), int'(item));
      end
    end
  end

  task automatic prog(input logic [AW-1:0] start, input int n, input logic [7:0] seed,
                      input bit part, input bit we, input bit pr, input bit poke,
                      input string req);
    logic [7:0] eb [PAGE];
    bit         ev [PAGE];
    int         off, nd, cnt;
    bit         commit;
    logic [AW-1:0] base;
    base = start & ~AW'(PAGE - 1);
    off  = int'(start) % PAGE;
    nd   = 0;
    for (int i = 0; i < PAGE; i++) ev[i] = 0;
    for (int i = 0; i < n; i++) begin
      eb[off] = seed + 8'(i * 29);
      ev[off] = 1;
      off = (off + 1) % PAGE;
    end
    commit = !part && we && !pr && (n > 0);
    if (commit) begin
      for (int o = 0; o < PAGE; o++) begin
        if (ev[o]) begin
          logic [AW-1:0] a;
          a = base | AW'(o);
          exp_mem[a] = exp_mem[a] & eb[o];
          sb_q.push_back({a, exp_mem[a]});
          nd++;
        end
      end
    end
    @(negedge clk);
    cmd_start = 1'b1; start_addr = start;
    @(negedge clk);
    cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = seed + 8'(i * 29);
      @(negedge clk);
      byte_valid = 1'b0;
    end
    cs_rise = 1'b1; partial = part; wen = we; prot = pr;
    @(negedge clk);
    cs_rise = 1'b0; partial = 1'b0;
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (poke && cnt == 2) begin
        cmd_start = 1'b1; start_addr = start ^ AW'(PAGE);
        byte_valid = 1'b1; byte_data = 8'h00; cs_rise = 1'b1;
      end else begin
        cmd_start = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0;
      end
      @(negedge clk);
    end
    cmd_start = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0;
    check(cnt == nd * BC, req, "busy cycles (R7)", cnt, nd * BC);
    check(wel_clr == commit, req, "wel pulse after busy (R8)", int'(wel_clr), int'(commit));
    @(negedge clk);
    check(wel_clr == 1'b0, "R8", "wel pulse one cycle", int'(wel_clr), 0);
    check(sb_q.size() == 0, req, "pending writes", sb_q.size(), 0);
    sb_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    cmd_start = 0; byte_valid = 0; cs_rise = 0; partial = 0;
    wen = 0; prot = 0; start_addr = '0; byte_data = '0;
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = 8'hFF; exp_mem[i] = 8'hFF;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(busy == 0,    "R11", "busy after reset",   int'(busy), 0);
    check(wel_clr == 0, "R11", "wel after reset",    int'(wel_clr), 0);
    check(mem_re == 0,  "R11", "mem_re after reset", int'(mem_re), 0);
    check(mem_we == 0,  "R11", "mem_we after reset", int'(mem_we), 0);

    // R1 start mid page, R12 ordered slots
    prog(8'h25, 3, 8'hA5, 0, 1, 0, 0, "R1");
    // R2 wrap inside the page
    prog(8'h3E, 5, 8'h5A, 0, 1, 0, 0, "R2");
    // R3 more than a page: overwrite
    prog(8'h43, 18, 8'hC3, 0, 1, 0, 0, "R3");
    // R5 partial byte discards
    prog(8'h60, 4, 8'h00, 1, 1, 0, 0, "R5");
    // R5 no bytes at all
    prog(8'h61, 0, 8'h00, 0, 1, 0, 0, "R5");
    // R6 write enable low / protected
    prog(8'h70, 2, 8'h00, 0, 0, 0, 0, "R6");
    prog(8'h70, 2, 8'h00, 0, 1, 1, 0, "R6");
    // R9 AND over earlier data
    prog(8'h80, 1, 8'hF0, 0, 1, 0, 0, "R9");
    prog(8'h80, 1, 8'h0F, 0, 1, 0, 0, "R9");
    check(mem[8'h80] == 8'h00, "R9", "AND result", int'(mem[8'h80]), 0);
    // R10 pulses during busy ignored
    prog(8'h9B, 6, 8'h3C, 0, 1, 0, 1, "R10");
    prog(8'hA0, 0, 8'h00, 0, 1, 0, 0, "R10");

    // R4 whole array matches expectation (unsupplied bytes untouched)
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, "R4", "array mismatches", bad, 0);
    check(mem[8'h20] == 8'hFF, "R4", "unsupplied byte", int'(mem[8'h20]), 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule